// File: doc/BRIEF.md
# Vertical On-Screen-Display Row Timing with Line Stretch

This block produces the vertical timing for a character overlay drawn on top of a video picture. It watches the vertical flyback input. On each falling edge it starts counting horizontal line strobes. After a programmable number of lines it begins walking through the pixel rows of each character cell, one cell row after another.

To let a fixed-height font fill screens with different line counts, a six-bit stretch code picks which font rows are emitted more than once. The two upper bits set how many times every row gets an extra copy. Each of the lower bits adds one extra copy to a fixed, evenly spread set of rows. Every extra copy comes directly after the row's normal occurrence and is flagged, so that the downstream pixel path can re-fetch the same font row.

The outputs are the font row index, the character-row index, a line-valid flag and a flag that marks the current line as a repeat. The block is driven by one clock, a one-cycle line strobe per horizontal line, and the flyback level.

Top module: `vosd_vpos`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `line_valid` and `line_repeat` are 0, and `row_idx` and `char_row` are 0.
- R2: After a falling edge of `vflb_in`, `line_valid` rises following exactly 4*`delay_code`+1 line strobes. The first valid line has `row_idx`=0, `char_row`=0 and `line_repeat`=0.
- R3: The outputs change only in the cycle after a line strobe or after a detected flyback fall. In all other cycles they hold their value.
- R4: `weight_code[5:4]` sets how many extra copies every font row 0..15 receives: 3 for the value 11, 2 for 10, and 1 for 00 or 01.
- R5: `weight_code[3]`=1 adds one more copy to each odd font row (1, 3, ..., 15).
- R6: `weight_code[2]`=1 adds one more copy to rows 2, 6, 10 and 14. `weight_code[1]`=1 adds one to rows 4 and 12. `weight_code[0]`=1 adds one to row 8.
- R7: All copies of a row follow its normal occurrence back to back, with `line_repeat`=1 and the same `row_idx`. The normal occurrence has `line_repeat`=0 and a `row_idx` one above the previous row, wrapping from 15 to 0.
- R8: A character row lasts 16 + 16*(3, 2 or 1 per R4) + `weight_code[3:0]` (as a binary number) line strobes. After row 15 of the last copy, `char_row` increments.
- R9: After the last line of character row NUM_CHAR_ROWS-1, `line_valid` goes to 0 and stays 0 whatever strobes arrive, until the next flyback fall.
- R10: A flyback fall at any time, including mid-frame, clears `line_valid` on the next cycle and restarts the delay count.
- R11: After reset and before the first flyback fall, `line_valid` stays 0 whatever strobes arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| vflb_in | input | 1 | Vertical flyback level; its falling edge starts a frame |
| line_stb | input | 1 | One-cycle pulse per horizontal line |
| delay_code | input | DELAY_W | Vertical delay in units of four lines (plus one) |
| weight_code | input | ROW_W+2 | Stretch code: upper two bits set the block count, lower bits set the per-set copies |
| line_valid | output | 1 | Current line belongs to the overlay |
| line_repeat | output | 1 | Current line is an extra copy of the previous font row |
| row_idx | output | ROW_W | Font row within the character cell |
| char_row | output | CROW_W | Character row on screen |

## Verification
Every output is registered once behind the line strobe. A strobe held high between two falling clock edges has its effect visible at the second falling edge, and the bench samples there after each strobe. A flyback fall passes through two synchronizer stages and an edge register before it reaches the sequencer, so the bench waits six cycles after dropping the flyback before its first check. To confirm R3, the bench also samples again after several idle cycles and compares the two readings.

// File: rtl/vosd_pkg.sv
package vosd_pkg;

   // Position of the lowest set bit of v; 32 when v is zero.
   function automatic int lsb_pos(input int v);
      for (int i = 0; i < 32; i++) begin
         if (v[i]) return i;
      end
      return 32;
   endfunction

   // Extra copies granted by the two-bit block field.
   function automatic logic [2:0] block_copies(input logic [1:0] fld);
      case (fld)
         2'b11:   return 3'd3;
         2'b10:   return 3'd2;
         default: return 3'd1;
      endcase
   endfunction

endpackage

// File: rtl/vosd_fall_det.sv
module vosd_fall_det #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic vflb,
   output logic fall
);
   logic cur;
   logic prev;

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign cur = vflb;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] sh;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh <= '0;
            else if (SYNC_STAGES == 1) sh <= vflb;
            else sh <= {sh[SYNC_STAGES-2:0], vflb};
         end
         assign cur = sh[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= 1'b0;
      else        prev <= cur;
   end

   assign fall = prev & ~cur;
endmodule

// File: rtl/vosd_delay_gate.sv
module vosd_delay_gate #(
   parameter int DELAY_W = 6
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               fall,
   input  logic               line_stb,
   input  logic [DELAY_W-1:0] delay_code,
   output logic               start
);
   localparam int CNT_W = DELAY_W + 3;

   logic             armed;
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] last_cnt;

   // 4*code+1 strobes: the strobe with count 4*code is the final one.
   assign last_cnt = {1'b0, delay_code, 2'b00};
   assign start    = armed & line_stb & ~fall & (cnt == last_cnt);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed <= 1'b0;
         cnt   <= '0;
      end else if (fall) begin
         armed <= 1'b1;
         cnt   <= '0;
      end else if (start) begin
         armed <= 1'b0;
         cnt   <= '0;
      end else if (armed && line_stb) begin
         cnt <= cnt + 1'b1;
      end
   end
endmodule

// File: rtl/vosd_repeat_map.sv
module vosd_repeat_map #(
   parameter int ROW_W = 4
) (
   input  logic [ROW_W+1:0] weight,
   input  logic [ROW_W-1:0] row,
   output logic [2:0]       copies
);
   import vosd_pkg::*;

   localparam int ROW_LINES = 1 << ROW_W;

   logic [2:0] blk;
   logic [2:0] per_row [ROW_LINES];

   assign blk = block_copies(weight[ROW_W+1:ROW_W]);

   // Row g belongs to the set picked by its lowest set bit: odd rows to
   // the top low bit, rows divisible by 2^k (but not 2^(k+1)) further down.
   generate
      for (genvar g = 0; g < ROW_LINES; g++) begin : g_row
         if (g == 0) begin : g_base
            assign per_row[g] = blk;
         end else begin : g_set
            localparam int TZ = lsb_pos(g);
            assign per_row[g] = blk + {2'b00, weight[ROW_W-1-TZ]};
         end
      end
   endgenerate

   assign copies = per_row[row];
endmodule

// File: rtl/vosd_row_seq.sv
module vosd_row_seq #(
   parameter int ROW_W         = 4,
   parameter int NUM_CHAR_ROWS = 15,
   parameter int CROW_W        = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fall,
   input  logic              start,
   input  logic              line_stb,
   input  logic [2:0]        copies,
   output logic              active,
   output logic              in_repeat,
   output logic [ROW_W-1:0]  row,
   output logic [CROW_W-1:0] crow
);
   localparam logic [ROW_W-1:0]  ROW_LAST  = {ROW_W{1'b1}};
   localparam logic [CROW_W-1:0] CROW_LAST = CROW_W'(NUM_CHAR_ROWS - 1);

   logic [2:0] pass;

   assign in_repeat = active & (pass != 3'd0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         pass   <= '0;
         row    <= '0;
         crow   <= '0;
      end else if (fall) begin
         active <= 1'b0;
         pass   <= '0;
         row    <= '0;
         crow   <= '0;
      end else if (start) begin
         active <= 1'b1;
         pass   <= '0;
         row    <= '0;
         crow   <= '0;
      end else if (active && line_stb) begin
         if (pass < copies) begin
            pass <= pass + 3'd1;
         end else begin
            pass <= '0;
            if (row == ROW_LAST) begin
               row <= '0;
               if (crow == CROW_LAST) begin
                  active <= 1'b0;
                  crow   <= '0;
               end else begin
                  crow <= crow + 1'b1;
               end
            end else begin
               row <= row + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/vosd_vpos.sv
module vosd_vpos #(
   parameter int DELAY_W       = 6,
   parameter int ROW_W         = 4,
   parameter int NUM_CHAR_ROWS = 15,
   parameter int SYNC_STAGES   = 2,
   localparam int CROW_W       = (NUM_CHAR_ROWS > 2) ? $clog2(NUM_CHAR_ROWS) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               vflb_in,
   input  logic               line_stb,
   input  logic [DELAY_W-1:0] delay_code,
   input  logic [ROW_W+1:0]   weight_code,
   output logic               line_valid,
   output logic               line_repeat,
   output logic [ROW_W-1:0]   row_idx,
   output logic [CROW_W-1:0]  char_row
);
   generate
      if (DELAY_W < 1 || DELAY_W > 16) begin : g_bad_delay
         $error("vosd_vpos: DELAY_W must lie in 1..16");
      end
      if (ROW_W < 2 || ROW_W > 6) begin : g_bad_row
         $error("vosd_vpos: ROW_W must lie in 2..6");
      end
      if (NUM_CHAR_ROWS < 1) begin : g_bad_crow
         $error("vosd_vpos: NUM_CHAR_ROWS must be at least 1");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("vosd_vpos: SYNC_STAGES must lie in 0..4");
      end
   endgenerate

   logic       fall_evt;
   logic       start_evt;
   logic [2:0] copies;

   vosd_fall_det #(.SYNC_STAGES(SYNC_STAGES)) u_fall (
      .clk   (clk),
      .rst_n (rst_n),
      .vflb  (vflb_in),
      .fall  (fall_evt)
   );

   vosd_delay_gate #(.DELAY_W(DELAY_W)) u_delay (
      .clk        (clk),
      .rst_n      (rst_n),
      .fall       (fall_evt),
      .line_stb   (line_stb),
      .delay_code (delay_code),
      .start      (start_evt)
   );

   vosd_repeat_map #(.ROW_W(ROW_W)) u_map (
      .weight (weight_code),
      .row    (row_idx),
      .copies (copies)
   );

   vosd_row_seq #(
      .ROW_W         (ROW_W),
      .NUM_CHAR_ROWS (NUM_CHAR_ROWS),
      .CROW_W        (CROW_W)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .fall      (fall_evt),
      .start     (start_evt),
      .line_stb  (line_stb),
      .copies    (copies),
      .active    (line_valid),
      .in_repeat (line_repeat),
      .row       (row_idx),
      .crow      (char_row)
   );
endmodule

// File: rtl/vosd_vpos_chk.sv
module vosd_vpos_chk #(
   parameter int ROW_W  = 4,
   parameter int CROW_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              line_stb,
   input logic              fall_evt,
   input logic              line_valid,
   input logic              line_repeat,
   input logic [ROW_W-1:0]  row_idx,
   input logic [CROW_W-1:0] char_row
);
   AST_FIRST_LINE_ROW0: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(line_valid) |-> (row_idx == '0 && char_row == '0 && !line_repeat)); // R2

   AST_HOLD_WITHOUT_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      (!line_stb && !fall_evt) |=> ($stable(line_valid) && $stable(line_repeat)
                                    && $stable(row_idx) && $stable(char_row))); // R3

   AST_REPEAT_KEEPS_ROW: assert property (@(posedge clk) disable iff (!rst_n)
      (line_stb && line_valid && !fall_evt) |=> (!line_repeat || row_idx == $past(row_idx))); // R7

   AST_NORMAL_ROW_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (line_stb && line_valid && !fall_evt) |=>
         (!line_valid || line_repeat || row_idx == ROW_W'($past(row_idx) + 1'b1))); // R7

   AST_REPEAT_ONLY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      line_repeat |-> line_valid); // R7

   AST_FALL_CLEARS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      fall_evt |=> !line_valid); // R10
endmodule

bind vosd_vpos vosd_vpos_chk #(.ROW_W(ROW_W), .CROW_W(CROW_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .line_stb    (line_stb),
   .fall_evt    (fall_evt),
   .line_valid  (line_valid),
   .line_repeat (line_repeat),
   .row_idx     (row_idx),
   .char_row    (char_row)
);

// File: tb/vosd_vpos_bench.sv
module vosd_vpos_bench;
   localparam int CLK_PERIOD = 10;
   localparam int NROWS      = 15;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       vflb_in = 1'b1;
   logic       line_stb = 1'b0;
   logic [5:0] delay_code = '0;
   logic [5:0] weight_code = '0;
   logic       line_valid;
   logic       line_repeat;
   logic [3:0] row_idx;
   logic [3:0] char_row;

   int n_tests = 0;
   int n_fail  = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   vosd_vpos #(.DELAY_W(6), .ROW_W(4), .NUM_CHAR_ROWS(NROWS), .SYNC_STAGES(2)) u_vosd_vpos (
      .clk(clk), .rst_n(rst_n), .vflb_in(vflb_in), .line_stb(line_stb),
      .delay_code(delay_code), .weight_code(weight_code),
      .line_valid(line_valid), .line_repeat(line_repeat),
      .row_idx(row_idx), .char_row(char_row)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic strobe();
      @(negedge clk) line_stb = 1'b1;
      @(negedge clk) line_stb = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic int exp_copies(input int k, input logic [5:0] w);
      int c;
      c = (w[5:4] == 2'b11) ? 3 : (w[5:4] == 2'b10) ? 2 : 1;
      if (k % 2 == 1)      c += w[3];
      else if (k % 4 == 2) c += w[2];
      else if (k % 8 == 4) c += w[1];
      else if (k == 8)     c += w[0];
      return c;
   endfunction

   function automatic string set_tag(input int k);
      if (k % 2 == 1) return "R5";
      if (k == 0)     return "R4";
      return "R6";
   endfunction

   task automatic drop_flyback();
      vflb_in = 1'b1;
      idle(4);
      vflb_in = 1'b0;
      idle(6);
      chk(line_valid == 1'b0, "R10", "valid after flyback fall", line_valid, 0);
   endtask

   task automatic run_delay(input int d);
      for (int i = 0; i < 4 * d; i++) begin
         strobe();
         chk(line_valid == 1'b0, "R2", "valid during delay", line_valid, 0);
      end
      strobe();
      chk(line_valid == 1'b1, "R2", "valid after last delay strobe", line_valid, 1);
      chk(row_idx == 0 && char_row == 0 && line_repeat == 0, "R2", "first line row",
          row_idx, 0);
   endtask

   task automatic walk_frame(input logic [5:0] w);
      int per_crow;
      int blk;
      blk = (w[5:4] == 2'b11) ? 48 : (w[5:4] == 2'b10) ? 32 : 16;
      for (int c = 0; c < NROWS; c++) begin
         int lines = 0;
         for (int k = 0; k < 16; k++) begin
            int n = exp_copies(k, w);
            for (int p = 0; p <= n; p++) begin
               chk(line_valid == 1'b1, "R8", "valid inside frame", line_valid, 1);
               chk(row_idx == k, set_tag(k), "row index", row_idx, k);
               chk(char_row == c, "R8", "char row", char_row, c);
               chk(line_repeat == (p > 0), "R7", "repeat flag", line_repeat, p > 0);
               if (c == 0 && k == 1 && p == 0) begin
                  idle(4);
                  chk(row_idx == 1 && line_repeat == 0 && line_valid == 1, "R3",
                      "hold between strobes", row_idx, 1);
               end
               lines++;
               strobe();
            end
         end
         per_crow = 16 + blk + int'(w[3:0]);
         chk(lines == per_crow, "R8", "lines per char row", lines, per_crow);
      end
      chk(line_valid == 1'b0, "R9", "valid after last char row", line_valid, 0);
      repeat (5) strobe();
      chk(line_valid == 1'b0 && line_repeat == 1'b0, "R9", "valid stays low",
          line_valid, 0);
   endtask

   task automatic test_reset();
      chk(line_valid == 0 && line_repeat == 0, "R1", "flags in reset", line_valid, 0);
      chk(row_idx == 0 && char_row == 0, "R1", "indices in reset", row_idx, 0);
      @(negedge clk) rst_n = 1'b1;
      @(negedge clk);
      chk(line_valid == 0 && row_idx == 0 && char_row == 0, "R1", "after reset release",
          line_valid, 0);
   endtask

   task automatic test_no_flyback();
      vflb_in = 1'b1;
      repeat (8) strobe();
      chk(line_valid == 1'b0, "R11", "valid before any flyback fall", line_valid, 0);
   endtask

   task automatic test_frame(input int d, input logic [5:0] w);
      delay_code  = 6'(d);
      weight_code = w;
      drop_flyback();
      run_delay(d);
      walk_frame(w);
   endtask

   task automatic test_abort();
      delay_code  = 6'd1;
      weight_code = 6'b10_0110;
      drop_flyback();
      run_delay(1);
      repeat (10) strobe();
      chk(line_valid == 1'b1, "R10", "valid mid frame", line_valid, 1);
      drop_flyback();
      chk(row_idx == 0 && char_row == 0, "R10", "indices cleared by fall", row_idx, 0);
      run_delay(1);
      walk_frame(weight_code);
   endtask

   initial begin
      idle(3);
      test_reset();
      test_no_flyback();
      test_frame(0, 6'b00_0000);
      test_frame(2, 6'b01_1000);
      test_frame(1, 6'b10_0100);
      test_frame(5, 6'b11_1111);
      test_frame(3, 6'b00_0011);
      test_abort();
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule